// File: doc/BRIEF.md
# ADC Tracking and Conversion Sequencer

This block is the digital timing core of a successive-approximation converter. A single subsystem clock drives it. A one-cycle convert-start pulse, a two-bit tracking-mode select, a tracking-length field and a divider setting together decide when the sampling switch is closed and when the bit-by-bit search runs. The block reports its phase, a busy flag and a one-cycle completion pulse. The search clock is not a separate clock. It is a strobe produced inside the subsystem clock domain.

The block has three tracking behaviours. In software-tracked mode, the sampler follows a track-request input while the block is idle, and a start pulse begins conversion at once. In timed mode, the start opens a tracking window of programmable length, and conversion follows immediately. The combined mode does both. After a conversion, timed mode parks the block idle with the switch open. The other two modes keep the switch closed until the next start. The block also holds a 10-bit trial code for the external DAC. It settles that code from the MSB down, one bit per strobe, using a comparator bit.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, phase is idle (2'b00), and busy, done, trk_en, sar_clk_en and result are all zero.
- R2: Phase is always one of three codes: idle 2'b00, tracking 2'b01, converting 2'b10.
- R3: With trk_mode 2'b10 (software-tracked), an accepted start enters conversion on the sampling edge with no timed tracking. Busy then stays high for exactly 13*(sar_div+1)+2 cycles.
- R4: With trk_mode 2'b01 (timed), 2'b11 (combined) or 2'b00 (reserved, acts as timed), an accepted start gives trk_len+2 cycles with trk_en and busy high. Conversion follows at once, and trk_en is low throughout conversion.
- R5: A conversion lasts 13*(sar_div+1)+2 cycles and carries exactly 13 sar_clk_en strobes. The first strobe comes sar_div+1 cycles after the conversion's first cycle, and later strobes are sar_div+1 cycles apart. No strobe appears outside conversion.
- R6: The trial code resolves MSB first, one bit per strobe. A bit stays set when cmp_in is 1 (input at or above sar_code) and is cleared otherwise. The final code equals the binary search result.
- R7: After done, modes 2'b01 and 2'b00 return to idle with trk_en low. Modes 2'b10 and 2'b11 go to tracking with trk_en high and busy low, and stay there until the next start.
- R8: A start pulse is ignored while busy (during timed tracking or conversion).
- R9: Busy rises in the cycle after the accepted start and falls in the cycle after done.
- R10: Done is high for exactly one cycle. Result takes the new code in that same cycle and holds it at all other times.
- R11: While idle in mode 2'b10, trk_en follows trk_req. While idle in any other mode, trk_en is low whatever trk_req does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Subsystem clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start | input | 1 | Convert-start pulse |
| trk_req | input | 1 | Software track request (mode 2'b10, idle) |
| trk_mode | input | 2 | Tracking mode select |
| trk_len | input | 4 | Timed tracking length minus 2 |
| sar_div | input | 3 | SAR strobe divide setting (period sar_div+1) |
| cmp_in | input | 1 | Comparator decision for current trial code |
| trk_en | output | 1 | Sampling switch enable |
| sar_clk_en | output | 1 | SAR clock-enable strobe |
| busy | output | 1 | Timed tracking or conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| phase | output | 2 | Current phase code |
| sar_code | output | 10 | Trial code to the DAC |
| result | output | 10 | Last completed conversion |

## Verification
The hardest situation to reach from the ports is a start pulse that lands while the block is already occupied. It matters most in the middle of a timed tracking window or partway through the strobe sequence, because accepting it there would silently restart the timing. The bench counts cycles from the accepted start and injects a second pulse at a fixed offset inside each of those phases. It then checks that the busy length, the strobe count and the result all match an undisturbed run. A reset that cuts a conversion short is provoked the same way, at a counted cycle offset, before a fresh conversion checks recovery.

// File: rtl/adc_seq_pkg.sv
// Package: shared phase codes, conversion sub-steps and mode encodings
// for the ADC sequencer. Assumes a two-bit mode field.
package adc_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_TRACK = 2'b01,
        PH_CONV  = 2'b10
    } phase_e;

    typedef enum logic [1:0] {
        CS_START = 2'b00,
        CS_BODY  = 2'b01,
        CS_FIN   = 2'b10
    } csub_e;

    localparam logic [1:0] MODE_RSV  = 2'b00;
    localparam logic [1:0] MODE_POST = 2'b01;
    localparam logic [1:0] MODE_PRE  = 2'b10;
    localparam logic [1:0] MODE_DUAL = 2'b11;
endpackage

// File: rtl/adc_sar_strobe.sv
// Strobe divider: produces a one-cycle enable every DIV+1 cycles while run
// is high. load presets the count so the first strobe arrives DIV+1 run
// cycles later. Assumes load and run are never high together.
module adc_sar_strobe #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             strobe
);
    logic [DIV_W-1:0] cnt_q;

    assign strobe = run && (cnt_q == '0);

    // Count down while running, reload on each strobe or on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load || strobe) begin
            cnt_q <= div;
        end else if (run) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/adc_track_timer.sv
// Tracking window timer: after load, expired goes high in the (len+2)-th
// cycle of the window. Assumes the caller leaves the window on expired.
module adc_track_timer #(
    parameter int TK_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            active,
    input  logic [TK_W-1:0] len,
    output logic            expired
);
    localparam int CW = TK_W + 1;

    logic [CW-1:0] cnt_q;

    assign expired = active && (cnt_q == '0);

    // Preload len+1 and count to zero, giving len+2 window cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(len) + CW'(1);
        end else if (active && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/adc_sar_reg.sv
// Successive-approximation register: init places the MSB trial, and each
// step settles the current bit from cmp and tries the next lower one. Once
// all bits are settled, further steps leave the code unchanged.
module adc_sar_reg #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             step,
    input  logic             cmp,
    output logic [RES_W-1:0] code
);
    localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};

    logic [RES_W-1:0] code_q;
    logic [RES_W-1:0] mask_q;
    logic [RES_W-1:0] kept;

    // Keep or clear the bit under trial, then set the next trial bit.
    always_comb begin
        kept = cmp ? code_q : (code_q & ~mask_q);
    end

    // Advance the one-hot trial pointer from MSB towards LSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            mask_q <= '0;
        end else if (init) begin
            code_q <= MSB_ONE;
            mask_q <= MSB_ONE;
        end else if (step && mask_q != '0) begin
            code_q <= kept | (mask_q >> 1);
            mask_q <= mask_q >> 1;
        end
    end

    assign code = code_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top: tracking/conversion phase controller. It accepts starts only when
// not busy, runs an optional timed tracking window, then a conversion of
// one start cycle, SAR_PERIODS strobe periods and one finish cycle.
// Assumes SAR_PERIODS > RES_W so the code has settled before the finish.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int SAR_PERIODS = 13,
    parameter int TK_W        = 4,
    parameter int DIV_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start,
    input  logic             trk_req,
    input  logic [1:0]       trk_mode,
    input  logic [TK_W-1:0]  trk_len,
    input  logic [DIV_W-1:0] sar_div,
    input  logic             cmp_in,
    output logic             trk_en,
    output logic             sar_clk_en,
    output logic             busy,
    output logic             done,
    output logic [1:0]       phase,
    output logic [RES_W-1:0] sar_code,
    output logic [RES_W-1:0] result
);
    localparam int PW = $clog2(SAR_PERIODS + 1);
    localparam logic [PW-1:0] LAST_PER = PW'(SAR_PERIODS - 1);

    phase_e           phase_q;
    csub_e            sub_q;
    logic             timed_q;
    logic [1:0]       mode_q;
    logic [PW-1:0]    per_q;
    logic [RES_W-1:0] result_q;

    logic pre_live, start_ok, enter_conv, timer_last, strobe, hold_after;
    logic in_body, in_timed;

    // Decode acceptance and phase-change conditions.
    always_comb begin
        pre_live   = (trk_mode == MODE_PRE);
        in_timed   = (phase_q == PH_TRACK) && timed_q;
        in_body    = (phase_q == PH_CONV) && (sub_q == CS_BODY);
        start_ok   = conv_start &&
                     ((phase_q == PH_IDLE) || (phase_q == PH_TRACK && !timed_q));
        enter_conv = (start_ok && pre_live) || timer_last;
        hold_after = (mode_q == MODE_PRE) || (mode_q == MODE_DUAL);
    end

    adc_track_timer #(.TK_W(TK_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start_ok && !pre_live),
        .active  (in_timed),
        .len     (trk_len),
        .expired (timer_last)
    );

    adc_sar_strobe #(.DIV_W(DIV_W)) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (enter_conv),
        .run    (in_body),
        .div    (sar_div),
        .strobe (strobe)
    );

    adc_sar_reg #(.RES_W(RES_W)) u_sar (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (enter_conv),
        .step  (strobe),
        .cmp   (cmp_in),
        .code  (sar_code)
    );

    // Phase sequencing, strobe period count and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            sub_q    <= CS_START;
            timed_q  <= 1'b0;
            mode_q   <= MODE_POST;
            per_q    <= '0;
            result_q <= '0;
        end else begin
            case (phase_q)
                PH_IDLE, PH_TRACK: begin
                    if (start_ok) begin
                        mode_q <= trk_mode;
                        if (pre_live) begin
                            phase_q <= PH_CONV;
                            sub_q   <= CS_START;
                            per_q   <= '0;
                        end else begin
                            phase_q <= PH_TRACK;
                            timed_q <= 1'b1;
                        end
                    end else if (timer_last) begin
                        phase_q <= PH_CONV;
                        sub_q   <= CS_START;
                        timed_q <= 1'b0;
                        per_q   <= '0;
                    end
                end
                PH_CONV: begin
                    case (sub_q)
                        CS_START: sub_q <= CS_BODY;
                        CS_BODY: begin
                            if (strobe) begin
                                per_q <= per_q + 1'b1;
                                if (per_q == LAST_PER) begin
                                    sub_q    <= CS_FIN;
                                    result_q <= sar_code;
                                end
                            end
                        end
                        default: begin
                            sub_q   <= CS_START;
                            phase_q <= hold_after ? PH_TRACK : PH_IDLE;
                            timed_q <= 1'b0;
                        end
                    endcase
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Output decode from the registered phase.
    always_comb begin
        trk_en     = (phase_q == PH_TRACK) ||
                     (phase_q == PH_IDLE && pre_live && trk_req);
        busy       = in_timed || (phase_q == PH_CONV);
        done       = (phase_q == PH_CONV) && (sub_q == CS_FIN);
        sar_clk_en = strobe;
        phase      = phase_q;
        result     = result_q;
    end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Checker: temporal properties of the sequencer ports, bound to the top.
module adc_seq_ctrl_chk #(
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trk_en,
    input logic             sar_clk_en,
    input logic             busy,
    input logic             done,
    input logic [1:0]       phase,
    input logic [RES_W-1:0] result
);
    p_phase_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 2'b11);

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    p_strobe_in_conv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sar_clk_en |-> phase == 2'b10);

    p_no_track_in_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 2'b10 |-> !trk_en);

    p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_busy_in_conv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 2'b10 |-> busy);

    p_track_to_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b01 && busy) |=> (phase == 2'b01 || phase == 2'b10));

    p_leave_conv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> phase != 2'b10);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.RES_W(RES_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trk_en     (trk_en),
    .sar_clk_en (sar_clk_en),
    .busy       (busy),
    .done       (done),
    .phase      (phase),
    .result     (result)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_start = 1'b0;
    logic       trk_req = 1'b0;
    logic [1:0] trk_mode = 2'b01;
    logic [3:0] trk_len = 4'd0;
    logic [2:0] sar_div = 3'd0;
    logic       cmp_in;
    logic       trk_en, sar_clk_en, busy, done;
    logic [1:0] phase;
    logic [9:0] sar_code, result;
    logic [9:0] v_in = 10'd0;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    // Ideal comparator against the bench's analog value.
    assign cmp_in = (v_in >= sar_code);

    adc_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .trk_req(trk_req),
        .trk_mode(trk_mode), .trk_len(trk_len), .sar_div(sar_div),
        .cmp_in(cmp_in), .trk_en(trk_en), .sar_clk_en(sar_clk_en),
        .busy(busy), .done(done), .phase(phase), .sar_code(sar_code),
        .result(result)
    );

    // {mode, trk_len, sar_div, analog value}
    localparam logic [18:0] VECS [0:7] = '{
        {2'b10, 4'd0,  3'd0, 10'h2A5},
        {2'b01, 4'd0,  3'd0, 10'h000},
        {2'b01, 4'd3,  3'd1, 10'h3FF},
        {2'b11, 4'd5,  3'd2, 10'h200},
        {2'b10, 4'd2,  3'd3, 10'h1FF},
        {2'b00, 4'd7,  3'd0, 10'h001},
        {2'b11, 4'd15, 3'd4, 10'h155},
        {2'b01, 4'd1,  3'd7, 10'h3FE}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Run one conversion; inj >= 0 injects an extra start at that cycle offset.
    task automatic run_conv(input logic [1:0] m, input int L, input int N,
                            input int V, input int inj);
        int  tk, k, c_busy, c_trk, c_stb, prev, res;
        bool_t: begin end
        tk = (m == 2'b10) ? 0 : L + 2;
        c_busy = 0; c_trk = 0; c_stb = 0; prev = -1; res = -1;
        @(negedge clk);
        trk_mode = m; trk_len = 4'(L); sar_div = 3'(N); v_in = 10'(V);
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        for (k = 0; k < 4000; k++) begin
            if (k == inj) conv_start = 1'b1;
            else conv_start = 1'b0;
            if (busy) c_busy++;
            if (busy && trk_en) c_trk++;
            if (sar_clk_en) begin
                c_stb++;
                if (prev < 0) chk(k == tk + 1 + N, "R5 first strobe offset", k, tk + 1 + N);
                else chk(k - prev == N + 1, "R5 strobe spacing", k - prev, N + 1);
                prev = k;
            end
            if (done) begin
                res = int'(result);
                break;
            end
            @(negedge clk);
        end
        conv_start = 1'b0;
        chk(c_busy == tk + 2 + 13 * (N + 1), (m == 2'b10) ? "R3 busy length" : "R9 busy length",
            c_busy, tk + 2 + 13 * (N + 1));
        chk(c_trk == tk, "R4 timed tracking cycles", c_trk, tk);
        chk(c_stb == 13, "R5 strobe count", c_stb, 13);
        chk(res == V, "R6 R10 result at done", res, V);
        @(negedge clk);
        chk(done == 1'b0, "R10 done single cycle", int'(done), 0);
        chk(busy == 1'b0, "R9 busy after done", int'(busy), 0);
        if (m == 2'b10 || m == 2'b11) begin
            chk(phase == 2'b01 && trk_en, "R7 hold tracking", int'(phase), 1);
        end else begin
            chk(phase == 2'b00 && !trk_en, "R7 back to idle", int'(phase), 0);
        end
        chk(result == 10'(V), "R10 result held", int'(result), V);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(phase == 2'b00 && !busy && !done && !trk_en && !sar_clk_en && result == 0,
            "R1 reset state", int'({phase, busy, done, trk_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(phase == 2'b00 && !busy, "R1 idle after release", int'(phase), 0);

        // R11: software track request in idle
        trk_mode = 2'b10; trk_req = 1'b1;
        #1;
        chk(trk_en == 1'b1, "R11 trk_req drives trk_en", int'(trk_en), 1);
        trk_req = 1'b0;
        #1;
        chk(trk_en == 1'b0, "R11 trk_req low", int'(trk_en), 0);
        trk_mode = 2'b01; trk_req = 1'b1;
        @(negedge clk);
        chk(trk_en == 1'b0 && phase == 2'b00, "R11 trk_req ignored in timed mode", int'(trk_en), 0);
        trk_req = 1'b0;

        // Vector table
        for (int i = 0; i < 8; i++) begin
            run_conv(VECS[i][18:17], int'(VECS[i][16:13]), int'(VECS[i][12:10]),
                     int'(VECS[i][9:0]), -1);
            chk(phase != 2'b11, "R2 phase code legal", int'(phase), 0);
        end

        // R8: starts during timed tracking and during conversion are ignored
        run_conv(2'b01, 4, 1, 10'h0F0, 1);
        run_conv(2'b11, 2, 2, 10'h30C, 12);
        run_conv(2'b10, 0, 2, 10'h0AA, 10);

        // Reset in the middle of a conversion, then recover
        @(negedge clk);
        trk_mode = 2'b01; trk_len = 4'd2; sar_div = 3'd1; v_in = 10'h123;
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        repeat (8) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk(phase == 2'b00 && !busy && result == 0, "R1 reset mid conversion",
            int'(result), 0);
        run_conv(2'b10, 0, 0, 10'h3C3, -1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule